// File: doc/BRIEF.md
# Two-Level Interrupt Priority Arbiter

This block chooses which pending interrupt source the CPU sequencer should vector to. Each source has a request flag, an enable bit and a one-bit priority level. When the sequencer raises its polling strobe, the block examines the requests that are eligible at that moment. It picks one request, taking the higher level first and then a fixed order inside the level. It answers with a one-cycle call request, the long-call target address and the index of the acknowledged source. For the sources whose flags the hardware clears on acknowledge, it also sends a clear pulse back to the flag.

The block keeps one in-progress bit for each priority level. While a level is in progress, requests of that level and of any lower level are held off. A higher-level request can still nest on top of a low-level routine. Only the interrupt-return pulse releases a level. A plain subroutine-return pulse leaves the state as it is, so a routine that exits with the wrong return keeps its level blocked. Saving the program counter on the stack is done elsewhere.

Top module: `intr_prio_arb`

## Requirements
- R1: After synchronous reset, `vec_req` and `flag_clr` are 0, `vec_addr` and `ack_src` are 0, and neither level is in progress, so the first eligible request is granted.
- R2: A grant happens only in a cycle where `poll_stb` is 1. It shows as `vec_req` = 1 for exactly the one cycle after that poll cycle, and `vec_req` is 0 whenever the previous cycle had no poll.
- R3: A source is eligible when its request, its enable and `glob_en` are all 1. Eligible sources with `src_hi` = 1 win over those with `src_hi` = 0. Inside a level the lowest index wins: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2.
- R4: With a grant, `ack_src` carries the winning index and `vec_addr` = 3 + 8 × index. Both hold their value until the next grant.
- R5: With `vec_req`, `flag_clr` pulses the winner's bit only if that bit of parameter `CLR_MASK` is 1 (default 6'b001111, so sources 4 and 5 are left to software). Otherwise it stays 0.
- R6: While the high level is in progress, nothing is granted. While only the low level is in progress, only high-level requests are granted.
- R7: An interrupt-return pulse clears the high in-progress bit if it is set, and otherwise clears the low one.
- R8: A plain-return pulse changes no in-progress state, so same and lower levels stay blocked.
- R9: With `glob_en` = 0 or `no_intr` = 1 during the poll cycle, no grant happens in that poll.
- R10: A grant sets the in-progress bit of the granted level. When an interrupt-return pulse and a poll fall in the same cycle, the arbitration sees the state from before the return, and the clear is applied before the set.
- R11: Request, enable and priority values are taken from the poll cycle itself, so a higher-level request raised at any time up to and including the poll cycle is chosen instead of a pending low-level one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_flags | input | NSRC | Interrupt request flags |
| src_en | input | NSRC | Per-source enable bits |
| src_hi | input | NSRC | Per-source priority level (1 = high) |
| glob_en | input | 1 | Global interrupt enable |
| no_intr | input | 1 | Current instruction must not be interrupted |
| poll_stb | input | 1 | Polling-point strobe from the sequencer |
| reti_pulse | input | 1 | Interrupt-return executed |
| ret_pulse | input | 1 | Plain return executed |
| vec_req | output | 1 | One-cycle long-call request |
| vec_addr | output | VEC_W | Call target address |
| ack_src | output | IDX_W | Index of the acknowledged source |
| flag_clr | output | NSRC | Per-source hardware flag-clear pulses |

## Verification
The interrupt-return pulse and a polling strobe can fall in the same cycle. In that case two things happen on one clock edge: the in-progress bits are released and a new level is granted. The bench drives both strobes together in every relevant state: high level busy, only low busy with a high request waiting, and only low busy with a low request waiting. It judges the outcome by whether a call request appears in that poll. It then uses later polls and further return pulses to read back, through the grant behaviour alone, which levels remain in progress.

// File: rtl/iarb_pkg.sv
package iarb_pkg;
  typedef enum logic {LVL_LO = 1'b0, LVL_HI = 1'b1} lvl_e;

  function automatic int unsigned vec_of(input int unsigned idx,
                                         input int unsigned base,
                                         input int unsigned stride);
    return base + stride * idx;
  endfunction
endpackage

// File: rtl/iarb_pick.sv
module iarb_pick #(
  parameter int N     = 6,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     cand,
  output logic             any,
  output logic [N-1:0]     onehot,
  output logic [IDX_W-1:0] idx
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_chain
      assign onehot[g]  = cand[g] & ~seen[g];
      assign seen[g+1]  = seen[g] | cand[g];
    end
  endgenerate

  assign any = seen[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++)
      if (onehot[i]) idx = IDX_W'(i);
  end
endmodule

// File: rtl/iarb_level_state.sv
module iarb_level_state (
  input  logic clk,
  input  logic rst,
  input  logic set_hi,
  input  logic set_lo,
  input  logic reti,
  output logic busy_hi,
  output logic busy_lo
);
  logic hi_n, lo_n;

  always_comb begin
    hi_n = busy_hi;
    lo_n = busy_lo;
    if (reti) begin
      if (busy_hi) hi_n = 1'b0;
      else         lo_n = 1'b0;
    end
    if (set_hi) hi_n = 1'b1;
    if (set_lo) lo_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_hi <= 1'b0;
      busy_lo <= 1'b0;
    end else begin
      busy_hi <= hi_n;
      busy_lo <= lo_n;
    end
  end

  assert_reti_hi_first_R7: assert property (@(posedge clk) disable iff (rst)
    (reti && busy_hi && !set_hi) |=> (!busy_hi && (busy_lo == $past(busy_lo) || $past(set_lo))));

  assert_reti_lo_R7: assert property (@(posedge clk) disable iff (rst)
    (reti && !busy_hi && !set_lo) |=> !busy_lo);

  assert_set_marks_R10: assert property (@(posedge clk) disable iff (rst)
    set_hi |=> busy_hi);
endmodule

// File: rtl/intr_prio_arb.sv
module intr_prio_arb #(
  parameter int          NSRC       = 6,
  parameter int          VEC_W      = 16,
  parameter int unsigned VEC_BASE   = 3,
  parameter int unsigned VEC_STRIDE = 8,
  parameter logic [NSRC-1:0] CLR_MASK = 6'b001111,
  localparam int         IDX_W      = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  req_flags,
  input  logic [NSRC-1:0]  src_en,
  input  logic [NSRC-1:0]  src_hi,
  input  logic             glob_en,
  input  logic             no_intr,
  input  logic             poll_stb,
  input  logic             reti_pulse,
  input  logic             ret_pulse,
  output logic             vec_req,
  output logic [VEC_W-1:0] vec_addr,
  output logic [IDX_W-1:0] ack_src,
  output logic [NSRC-1:0]  flag_clr
);
  import iarb_pkg::*;

  logic [NSRC-1:0]  elig, hi_cand, lo_cand, hi_oh, lo_oh, sel_oh;
  logic             hi_any, lo_any, take_hi, take_lo, grant;
  logic [IDX_W-1:0] hi_idx, lo_idx, sel_idx;
  logic             busy_hi, busy_lo;
  lvl_e             sel_lvl;

  assign elig    = req_flags & src_en & {NSRC{glob_en & ~no_intr}};
  assign hi_cand = elig & src_hi;
  assign lo_cand = elig & ~src_hi;

  iarb_pick #(.N(NSRC), .IDX_W(IDX_W)) u_pick_hi (
    .cand(hi_cand), .any(hi_any), .onehot(hi_oh), .idx(hi_idx));
  iarb_pick #(.N(NSRC), .IDX_W(IDX_W)) u_pick_lo (
    .cand(lo_cand), .any(lo_any), .onehot(lo_oh), .idx(lo_idx));

  assign take_hi = poll_stb && hi_any && !busy_hi;
  assign take_lo = poll_stb && !hi_any && lo_any && !busy_hi && !busy_lo;
  assign grant   = take_hi || take_lo;
  assign sel_lvl = take_hi ? LVL_HI : LVL_LO;
  assign sel_idx = (sel_lvl == LVL_HI) ? hi_idx : lo_idx;
  assign sel_oh  = (sel_lvl == LVL_HI) ? hi_oh  : lo_oh;

  iarb_level_state u_state (
    .clk(clk), .rst(rst),
    .set_hi(take_hi), .set_lo(take_lo), .reti(reti_pulse),
    .busy_hi(busy_hi), .busy_lo(busy_lo));

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_req  <= 1'b0;
      vec_addr <= '0;
      ack_src  <= '0;
      flag_clr <= '0;
    end else begin
      vec_req  <= grant;
      flag_clr <= grant ? (sel_oh & CLR_MASK) : '0;
      if (grant) begin
        ack_src  <= sel_idx;
        vec_addr <= VEC_W'(vec_of(int'(sel_idx), VEC_BASE, VEC_STRIDE));
      end
    end
  end

  assert_req_after_poll_R2: assert property (@(posedge clk) disable iff (rst)
    vec_req |-> $past(poll_stb));

  assert_addr_matches_src_R4: assert property (@(posedge clk) disable iff (rst)
    vec_req |-> (vec_addr == VEC_W'(VEC_BASE + VEC_STRIDE * ack_src)));

  assert_clr_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(flag_clr) && (flag_clr == '0 || vec_req));

  assert_hi_blocks_all_R6: assert property (@(posedge clk) disable iff (rst)
    (poll_stb && busy_hi) |=> !vec_req);

  assert_ret_no_effect_R8: assert property (@(posedge clk) disable iff (rst)
    (ret_pulse && !reti_pulse && !poll_stb) |=> ($stable(busy_hi) && $stable(busy_lo)));

  assert_gated_poll_R9: assert property (@(posedge clk) disable iff (rst)
    (poll_stb && (!glob_en || no_intr)) |=> !vec_req);
endmodule

// File: tb/sim_intr_prio_arb.sv
`timescale 1ns/1ps
module sim_intr_prio_arb;
  localparam int N = 6;
  localparam logic [N-1:0] MASK = 6'b001111;

  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] req_flags = '0, src_en = '0, src_hi = '0;
  logic glob_en = 1'b0, no_intr = 1'b0, poll_stb = 1'b0;
  logic reti_pulse = 1'b0, ret_pulse = 1'b0;
  logic vec_req;
  logic [15:0] vec_addr;
  logic [2:0] ack_src;
  logic [N-1:0] flag_clr;

  int checks = 0, errors = 0;
  bit m_hi = 0, m_lo = 0, done = 0;

  always #2.5 clk = ~clk;

  intr_prio_arb u0 (
    .clk(clk), .rst(rst), .req_flags(req_flags), .src_en(src_en), .src_hi(src_hi),
    .glob_en(glob_en), .no_intr(no_intr), .poll_stb(poll_stb),
    .reti_pulse(reti_pulse), .ret_pulse(ret_pulse),
    .vec_req(vec_req), .vec_addr(vec_addr), .ack_src(ack_src), .flag_clr(flag_clr));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // expected winner from requirements R3, R6, R9; -1 when nothing is granted
  function automatic int model_pick();
    int w;
    w = -1;
    if (!glob_en || no_intr || m_hi) return -1;
    for (int i = N-1; i >= 0; i--)
      if (req_flags[i] && src_en[i] && src_hi[i]) w = i;
    if (w >= 0) return w;
    if (m_lo) return -1;
    for (int i = N-1; i >= 0; i--)
      if (req_flags[i] && src_en[i] && !src_hi[i]) w = i;
    return w;
  endfunction

  // poll (optionally with an interrupt-return in the same cycle) and check the result
  task automatic poll_chk(input string tag, input bit with_reti);
    int w;
    bit lvl;
    w = model_pick();
    lvl = (w >= 0) ? src_hi[w] : 1'b0;
    poll_stb = 1'b1;
    reti_pulse = with_reti;
    @(negedge clk);
    poll_stb = 1'b0;
    reti_pulse = 1'b0;
    if (with_reti) begin
      if (m_hi) m_hi = 0; else m_lo = 0;
    end
    if (w >= 0) begin
      if (lvl) m_hi = 1; else m_lo = 1;
    end
    chk({tag, " R2 vec_req"}, int'(vec_req), (w >= 0) ? 1 : 0);
    if (w >= 0) begin
      chk({tag, " R3 ack_src"}, int'(ack_src), w);
      chk({tag, " R4 vec_addr"}, int'(vec_addr), 3 + 8 * w);
      chk({tag, " R5 flag_clr"}, int'(flag_clr), MASK[w] ? (1 << w) : 0);
    end else begin
      chk({tag, " R5 flag_clr idle"}, int'(flag_clr), 0);
    end
  endtask

  task automatic do_reti();
    reti_pulse = 1'b1;
    @(negedge clk);
    reti_pulse = 1'b0;
    if (m_hi) m_hi = 0; else m_lo = 0;
  endtask

  task automatic clear_all();
    while (m_hi || m_lo) do_reti();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 vec_req after reset", int'(vec_req), 0);
    chk("R1 flag_clr after reset", int'(flag_clr), 0);
    chk("R1 vec_addr after reset", int'(vec_addr), 0);
    chk("R1 ack_src after reset", int'(ack_src), 0);

    glob_en = 1; src_en = '1; src_hi = '0; req_flags = 6'b100000;
    poll_stb = 0;
    @(negedge clk);
    chk("R2 no poll no request", int'(vec_req), 0);
    poll_chk("R1 first low grant", 0);
    @(negedge clk);
    chk("R2 vec_req one cycle", int'(vec_req), 0);
    chk("R4 ack_src held", int'(ack_src), 5);
    clear_all();

    // R3/R4/R5 sweep: every request pattern against every priority pattern
    for (int r = 0; r < 64; r++)
      for (int h = 0; h < 64; h++) begin
        req_flags = N'(r); src_hi = N'(h); src_en = '1;
        poll_chk("R3 sweep req x prio", 0);
        clear_all();
      end
    // enable sweep
    for (int e = 0; e < 64; e++)
      for (int r = 0; r < 64; r++) begin
        req_flags = N'(r); src_hi = 6'b010010; src_en = N'(e);
        poll_chk("R3 sweep enable", 0);
        clear_all();
      end

    // R9 gating
    req_flags = 6'b000001; src_en = '1; src_hi = '0;
    glob_en = 0; poll_chk("R9 global off", 0);
    glob_en = 1; no_intr = 1; poll_chk("R9 no_intr", 0);
    no_intr = 0;

    // R6 / R8 nesting
    req_flags = 6'b000100; src_hi = '0;
    poll_chk("R6 low grant", 0);
    req_flags = 6'b000001; poll_chk("R6 low blocked by low", 0);
    ret_pulse = 1; @(negedge clk); ret_pulse = 0;
    poll_chk("R8 ret keeps low blocked", 0);
    req_flags = 6'b001001; src_hi = 6'b001000;
    poll_chk("R6 high nests on low", 0);
    req_flags = 6'b101001; src_hi = 6'b101000;
    poll_chk("R6 high blocks high", 0);
    ret_pulse = 1; @(negedge clk); ret_pulse = 0;
    poll_chk("R8 ret keeps high blocked", 0);
    do_reti();
    req_flags = 6'b000001; src_hi = '0;
    poll_chk("R7 reti cleared high only", 0);
    do_reti();
    poll_chk("R7 reti cleared low", 0);
    clear_all();

    // R10 same-cycle reti and poll
    req_flags = 6'b000010; src_hi = 6'b000010;
    poll_chk("R10 high busy", 0);
    poll_chk("R10 reti+poll high sees old", 1);
    poll_chk("R10 high free after", 0);
    clear_all();
    req_flags = 6'b000001; src_hi = '0;
    poll_chk("R10 low busy", 0);
    poll_chk("R10 reti+poll low sees old", 1);
    poll_chk("R10 low free after", 0);
    clear_all();
    poll_chk("R10 low busy again", 0);
    req_flags = 6'b010000; src_hi = 6'b010000;
    poll_chk("R10 reti+poll high over low", 1);
    req_flags = 6'b000001; src_hi = '0;
    poll_chk("R10 high still set", 0);
    do_reti();
    poll_chk("R10 low was cleared", 0);
    clear_all();

    // R11 late high request
    req_flags = 6'b000001; src_hi = 6'b000000;
    @(negedge clk);
    req_flags = 6'b100001; src_hi = 6'b100000;
    poll_chk("R11 late high wins", 0);
    chk("R11 ack is late source", int'(ack_src), 5);
    clear_all();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule